// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block decides when an 8-bit processor core takes an interrupt and produces the dispatch sequence for it. It holds five interrupt request bits, five matching enable bits, a master enable flag, a halted flag and a one-instruction delay flag that follows the enable-interrupts instruction. The core pulses `boundary_i` at every instruction boundary. The unit then either consumes the pending delay, wakes the core from halt, or dispatches the lowest-numbered pending line. Dispatch pushes the return address byte by byte through a stack write port, then loads a new stack pointer and a fixed vector address into the core.

Each boundary check yields an event record one cycle later: whether a dispatch started, how many stall cycles the core must insert, and whether the next opcode byte must be fetched again. A parameter picks between two halt-exit variants. The legacy variant adds no wake cycles and repeats the fetch when it wakes with the master enable off. The newer variant charges wake cycles instead. Opcode decoding and the arithmetic unit belong to the core.

Top module: `irq_dispatch_unit`

## Requirements
- R1: A line n (0..4) is pending only when enable bit n and request bit n are both set. The read port returns the enable register when `reg_sel_i`=0 and the request register when `reg_sel_i`=1, with bit n for line n. A write through the port replaces the selected register.
- R2: When several lines are pending at a boundary, the lowest-numbered one is dispatched.
- R3: The dispatch target loaded into the program counter is 0x40 + 8*n for winning line n.
- R4: A dispatch clears the master enable and the winning request bit. The other request bits and the enable register keep their values.
- R5: In the three cycles after the dispatch event, the unit writes the low return byte at SP-2, then the high return byte at SP-1, then loads PC with the vector and SP with SP-2. SP and PC here are the values presented at the boundary.
- R6: A dispatch event from a running core reports 20 stall cycles: 12 internal plus two 4-cycle writes.
- R7: The first boundary after the enable-interrupts strobe performs no check. It reports an event with 0 cycles and no dispatch, and it clears the delay. The following boundary may dispatch.
- R8: At a boundary, any pending line clears the halted flag, even with the master enable off. In that case no dispatch happens and the request bits are unchanged.
- R9: In the legacy variant, a wake from halt with the master enable off raises the refetch flag in its event. The newer variant never raises it.
- R10: In the newer variant, a wake from halt adds 4 cycles. It adds 4 more when the master enable is off and a halted boundary with nothing pending has already passed since halt entry. The legacy variant adds no wake cycles, so a wake with dispatch costs 24 (new) or 20 (legacy).
- R11: A boundary while halted with nothing pending keeps the core halted and reports 4 cycles (newer) or 2 cycles (legacy).
- R12: A rising level on a request input sets its request bit, and a falling level clears it.
- R13: After reset both registers read 0, the master enable and halted flag are 0, and no event, stack write or load is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_line_i | input | 5 | Interrupt request levels, one per line |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 enable, 1 request |
| reg_wdata_i | input | 5 | Register write data |
| reg_rdata_o | output | 5 | Selected register contents |
| ei_i | input | 1 | Enable-interrupts instruction executed |
| di_i | input | 1 | Disable-interrupts instruction executed |
| halt_i | input | 1 | Halt instruction executed |
| boundary_i | input | 1 | Instruction boundary check strobe |
| pc_i | input | 16 | Current program counter (return address) |
| sp_i | input | 16 | Current stack pointer |
| ime_o | output | 1 | Master enable flag |
| halted_o | output | 1 | Core halted flag |
| busy_o | output | 1 | Dispatch sequence in progress |
| stk_we_o | output | 1 | Stack byte write strobe |
| stk_addr_o | output | 16 | Stack write address |
| stk_data_o | output | 8 | Stack write byte |
| pc_load_o | output | 1 | Load program counter |
| pc_val_o | output | 16 | Program counter load value |
| sp_load_o | output | 1 | Load stack pointer |
| sp_val_o | output | 16 | Stack pointer load value |
| evt_valid_o | output | 1 | Boundary event record valid |
| evt_disp_o | output | 1 | Event started a dispatch |
| evt_cyc_o | output | 8 | Stall cycles charged by the event |
| refetch_o | output | 1 | Next opcode byte must be fetched again |

## Verification
The hardest case to reach is the wake-cycle split in the newer variant. The extra 4 cycles depend on whether a quiet halted boundary came before the wake, and that history is not visible at any port. The bench brings the core into halt with the master enable off. In one run it issues a boundary with nothing pending before raising a request, and in the other it raises the request at once. It runs a legacy instance on the same stimulus, so cycle counts and the refetch flag can be compared side by side. Priority and vector selection are swept across all 1024 enable/request combinations, and each dispatch has its full push-and-load sequence checked.

// File: rtl/irq_dispatch_pkg.sv
// Shared definitions for the interrupt dispatch unit.
// Assumes a 16-bit address space pushed as two bytes, low byte first.
package irq_dispatch_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_PUSH_LO = 2'd1,
        SEQ_PUSH_HI = 2'd2,
        SEQ_JUMP    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/irq_req_regs.sv
// Enable and request registers for the interrupt lines.
// Request bits follow level edges on the lines, can be overwritten by the
// register port, and lose the acknowledged bit on dispatch.
// Assumes ack_i is a single-cycle one-hot pulse from the sequencer.
module irq_req_regs #(
    parameter int N_LINES = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_i,
    input  logic               we_i,
    input  logic               sel_i,
    input  logic [N_LINES-1:0] wdata_i,
    input  logic [N_LINES-1:0] ack_i,
    output logic [N_LINES-1:0] en_o,
    output logic [N_LINES-1:0] req_o
);
    logic [N_LINES-1:0] en_q;
    logic [N_LINES-1:0] req_q;
    logic [N_LINES-1:0] line_q;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] fall;
    logic [N_LINES-1:0] req_base;
    logic [N_LINES-1:0] req_nxt;

    // Edge detection on the request levels.
    always_comb begin
        rise = line_i & ~line_q;
        fall = ~line_i & line_q;
    end

    // Next request value: port write, then edges, then acknowledge.
    always_comb begin
        req_base = (we_i && sel_i) ? wdata_i : req_q;
        req_nxt  = (req_base | rise) & ~fall & ~ack_i;
    end

    // Register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            req_q  <= '0;
            line_q <= '0;
        end else begin
            line_q <= line_i;
            req_q  <= req_nxt;
            if (we_i && !sel_i) en_q <= wdata_i;
        end
    end

    assign en_o  = en_q;
    assign req_o = req_q;

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_i)); // R2
    AST_ACK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i & ~(en_q & req_q)) == '0); // R1
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i != '0 && !we_i && (rise & ack_i) == '0) |=> ((req_q & $past(ack_i)) == '0)); // R4
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority selector: lowest-numbered pending line wins.
// Purely combinational; built as a blocking chain so it scales with N_LINES.
module irq_prio_pick #(
    parameter int N_LINES = 5,
    parameter int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] pend_i,
    output logic               any_o,
    output logic [N_LINES-1:0] onehot_o,
    output logic [IDX_W-1:0]   idx_o
);
    logic [N_LINES:0] blocked;

    assign blocked[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N_LINES; g++) begin : g_chain
            assign onehot_o[g]  = pend_i[g] & ~blocked[g];
            assign blocked[g+1] = blocked[g] | pend_i[g];
        end
    endgenerate

    // Encode the one-hot winner into an index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (onehot_o[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = blocked[N_LINES];
endmodule

// File: rtl/irq_seq.sv
// Boundary checker and dispatch sequencer.
// Holds the master enable, halted, entering-halt and enable-delay flags,
// evaluates each instruction boundary, and runs the push/jump sequence.
// Assumes the core issues no boundary while busy_o is high, and that
// ei/di/halt strobes override flag updates made by a coincident boundary.
module irq_seq
    import irq_dispatch_pkg::*;
#(
    parameter int N_LINES       = 5,
    parameter int IDX_W         = 3,
    parameter int CYC_W         = 8,
    parameter int VEC_BASE      = 'h40,
    parameter int VEC_STRIDE    = 8,
    parameter int DISP_INT_CYC  = 12,
    parameter int MEM_CYC       = 4,
    parameter int WAKE_CYC      = 4,
    parameter int HALT_IDLE_NEW = 4,
    parameter int HALT_IDLE_OLD = 2,
    parameter bit LEGACY_WAKE   = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boundary_i,
    input  logic               ei_i,
    input  logic               di_i,
    input  logic               halt_i,
    input  logic               any_i,
    input  logic [N_LINES-1:0] win_oh_i,
    input  logic [IDX_W-1:0]   win_idx_i,
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic [ADDR_W-1:0]  sp_i,
    output logic [N_LINES-1:0] ack_o,
    output logic               ime_o,
    output logic               halted_o,
    output logic               busy_o,
    output logic               stk_we_o,
    output logic [ADDR_W-1:0]  stk_addr_o,
    output logic [BYTE_W-1:0]  stk_data_o,
    output logic               pc_load_o,
    output logic [ADDR_W-1:0]  pc_val_o,
    output logic               sp_load_o,
    output logic [ADDR_W-1:0]  sp_val_o,
    output logic               evt_valid_o,
    output logic               evt_disp_o,
    output logic [CYC_W-1:0]   evt_cyc_o,
    output logic               refetch_o
);
    localparam int DISP_CYC = DISP_INT_CYC + 2 * MEM_CYC;
    localparam int IDLE_CYC = LEGACY_WAKE ? HALT_IDLE_OLD : HALT_IDLE_NEW;

    seq_state_e        st_q;
    logic              ime_q;
    logic              halted_q;
    logic              entering_q;
    logic              delay_q;
    logic [ADDR_W-1:0] ret_q;
    logic [ADDR_W-1:0] sp_new_q;
    logic [ADDR_W-1:0] vec_q;
    logic              evt_valid_q;
    logic              evt_disp_q;
    logic [CYC_W-1:0]  evt_cyc_q;
    logic              refetch_q;
    logic              check;
    logic              take;
    logic [CYC_W-1:0]  wake_cyc;
    logic [ADDR_W-1:0] vec_addr;

    // Qualify the boundary: idle, no delay pending.
    always_comb begin
        check = (st_q == SEQ_IDLE) && boundary_i && !delay_q;
        take  = check && any_i && ime_q;
        ack_o = take ? win_oh_i : '0;
    end

    // Wake penalty for the selected halt-exit variant.
    always_comb begin
        wake_cyc = '0;
        if (halted_q && !LEGACY_WAKE) begin
            wake_cyc = CYC_W'(WAKE_CYC);
            if (!ime_q && !entering_q) wake_cyc = CYC_W'(2 * WAKE_CYC);
        end
    end

    // Vector address of the winning line.
    always_comb begin
        vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'(win_idx_i) * ADDR_W'(VEC_STRIDE);
    end

    // Flag, sequence and event register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= SEQ_IDLE;
            ime_q       <= 1'b0;
            halted_q    <= 1'b0;
            entering_q  <= 1'b0;
            delay_q     <= 1'b0;
            ret_q       <= '0;
            sp_new_q    <= '0;
            vec_q       <= '0;
            evt_valid_q <= 1'b0;
            evt_disp_q  <= 1'b0;
            evt_cyc_q   <= '0;
            refetch_q   <= 1'b0;
        end else begin
            evt_valid_q <= 1'b0;
            evt_disp_q  <= 1'b0;
            evt_cyc_q   <= '0;
            refetch_q   <= 1'b0;
            unique case (st_q)
                SEQ_IDLE: begin
                    if (boundary_i) begin
                        evt_valid_q <= 1'b1;
                        if (delay_q) begin
                            delay_q <= 1'b0;
                        end else if (any_i) begin
                            halted_q  <= 1'b0;
                            refetch_q <= halted_q && LEGACY_WAKE && !ime_q;
                            if (ime_q) begin
                                ime_q      <= 1'b0;
                                st_q       <= SEQ_PUSH_LO;
                                ret_q      <= pc_i;
                                sp_new_q   <= sp_i - ADDR_W'(2);
                                vec_q      <= vec_addr;
                                evt_disp_q <= 1'b1;
                                evt_cyc_q  <= wake_cyc + CYC_W'(DISP_CYC);
                            end else begin
                                evt_cyc_q <= wake_cyc;
                            end
                        end else if (halted_q) begin
                            entering_q <= 1'b0;
                            evt_cyc_q  <= CYC_W'(IDLE_CYC);
                        end
                    end
                end
                SEQ_PUSH_LO: st_q <= SEQ_PUSH_HI;
                SEQ_PUSH_HI: st_q <= SEQ_JUMP;
                SEQ_JUMP:    st_q <= SEQ_IDLE;
                default:     st_q <= SEQ_IDLE;
            endcase
            if (ei_i) begin
                ime_q   <= 1'b1;
                delay_q <= 1'b1;
            end
            if (di_i) begin
                ime_q   <= 1'b0;
                delay_q <= 1'b0;
            end
            if (halt_i) begin
                halted_q   <= 1'b1;
                entering_q <= 1'b1;
            end
        end
    end

    // Stack write and load outputs decoded from the sequence state.
    always_comb begin
        stk_we_o   = (st_q == SEQ_PUSH_LO) || (st_q == SEQ_PUSH_HI);
        stk_addr_o = (st_q == SEQ_PUSH_HI) ? sp_new_q + ADDR_W'(1) : sp_new_q;
        stk_data_o = (st_q == SEQ_PUSH_HI) ? ret_q[ADDR_W-1:BYTE_W] : ret_q[BYTE_W-1:0];
        pc_load_o  = (st_q == SEQ_JUMP);
        sp_load_o  = (st_q == SEQ_JUMP);
        pc_val_o   = vec_q;
        sp_val_o   = sp_new_q;
    end

    assign ime_o       = ime_q;
    assign halted_o    = halted_q;
    assign busy_o      = (st_q != SEQ_IDLE);
    assign evt_valid_o = evt_valid_q;
    assign evt_disp_o  = evt_disp_q;
    assign evt_cyc_o   = evt_cyc_q;
    assign refetch_o   = refetch_q;

    AST_DISPATCH_DROPS_IME: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o != '0 && !ei_i) |=> !ime_o); // R4
    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we_o && !$stable(st_q) && st_q == SEQ_PUSH_LO) |=> (stk_we_o && stk_addr_o == $past(stk_addr_o) + ADDR_W'(1))); // R5
    AST_JUMP_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_PUSH_HI) |=> (pc_load_o && sp_load_o && !stk_we_o)); // R5
    AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> ((pc_val_o - ADDR_W'(VEC_BASE)) % ADDR_W'(VEC_STRIDE)) == '0); // R3
    AST_DELAY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == SEQ_IDLE) && boundary_i && delay_q && !ei_i) |=> (!busy_o && !evt_disp_o)); // R7
    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (check && any_i && !halt_i) |=> !halted_o); // R8
    AST_REFETCH_VARIANT: assert property (@(posedge clk) disable iff (!rst_n)
        refetch_o |-> (LEGACY_WAKE && !evt_disp_o)); // R9
endmodule

// File: rtl/irq_dispatch_unit.sv
// Top of the interrupt dispatch unit.
// Wires the request/enable registers, the priority selector and the
// boundary sequencer; the read port is a plain combinational mux.
// Assumes a 16-bit program counter and stack pointer.
module irq_dispatch_unit
    import irq_dispatch_pkg::*;
#(
    parameter int N_LINES       = 5,
    parameter int CYC_W         = 8,
    parameter int VEC_BASE      = 'h40,
    parameter int VEC_STRIDE    = 8,
    parameter int DISP_INT_CYC  = 12,
    parameter int MEM_CYC       = 4,
    parameter int WAKE_CYC      = 4,
    parameter int HALT_IDLE_NEW = 4,
    parameter int HALT_IDLE_OLD = 2,
    parameter bit LEGACY_WAKE   = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_line_i,
    input  logic               reg_we_i,
    input  logic               reg_sel_i,
    input  logic [N_LINES-1:0] reg_wdata_i,
    output logic [N_LINES-1:0] reg_rdata_o,
    input  logic               ei_i,
    input  logic               di_i,
    input  logic               halt_i,
    input  logic               boundary_i,
    input  logic [15:0]        pc_i,
    input  logic [15:0]        sp_i,
    output logic               ime_o,
    output logic               halted_o,
    output logic               busy_o,
    output logic               stk_we_o,
    output logic [15:0]        stk_addr_o,
    output logic [7:0]         stk_data_o,
    output logic               pc_load_o,
    output logic [15:0]        pc_val_o,
    output logic               sp_load_o,
    output logic [15:0]        sp_val_o,
    output logic               evt_valid_o,
    output logic               evt_disp_o,
    output logic [CYC_W-1:0]   evt_cyc_o,
    output logic               refetch_o
);
    localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    logic [N_LINES-1:0] en;
    logic [N_LINES-1:0] req;
    logic [N_LINES-1:0] pend;
    logic [N_LINES-1:0] win_oh;
    logic [N_LINES-1:0] ack;
    logic [IDX_W-1:0]   win_idx;
    logic               any_pend;

    irq_req_regs #(
        .N_LINES (N_LINES)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (irq_line_i),
        .we_i    (reg_we_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .ack_i   (ack),
        .en_o    (en),
        .req_o   (req)
    );

    // A line is pending when enabled and requested.
    assign pend = en & req;

    // Register read mux.
    assign reg_rdata_o = reg_sel_i ? req : en;

    irq_prio_pick #(
        .N_LINES (N_LINES),
        .IDX_W   (IDX_W)
    ) u_pick (
        .pend_i   (pend),
        .any_o    (any_pend),
        .onehot_o (win_oh),
        .idx_o    (win_idx)
    );

    irq_seq #(
        .N_LINES       (N_LINES),
        .IDX_W         (IDX_W),
        .CYC_W         (CYC_W),
        .VEC_BASE      (VEC_BASE),
        .VEC_STRIDE    (VEC_STRIDE),
        .DISP_INT_CYC  (DISP_INT_CYC),
        .MEM_CYC       (MEM_CYC),
        .WAKE_CYC      (WAKE_CYC),
        .HALT_IDLE_NEW (HALT_IDLE_NEW),
        .HALT_IDLE_OLD (HALT_IDLE_OLD),
        .LEGACY_WAKE   (LEGACY_WAKE)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary_i  (boundary_i),
        .ei_i        (ei_i),
        .di_i        (di_i),
        .halt_i      (halt_i),
        .any_i       (any_pend),
        .win_oh_i    (win_oh),
        .win_idx_i   (win_idx),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .ack_o       (ack),
        .ime_o       (ime_o),
        .halted_o    (halted_o),
        .busy_o      (busy_o),
        .stk_we_o    (stk_we_o),
        .stk_addr_o  (stk_addr_o),
        .stk_data_o  (stk_data_o),
        .pc_load_o   (pc_load_o),
        .pc_val_o    (pc_val_o),
        .sp_load_o   (sp_load_o),
        .sp_val_o    (sp_val_o),
        .evt_valid_o (evt_valid_o),
        .evt_disp_o  (evt_disp_o),
        .evt_cyc_o   (evt_cyc_o),
        .refetch_o   (refetch_o)
    );
endmodule

// File: tb/irq_dispatch_unit_tb.sv
// Bench: newer-variant instance u_dut and legacy instance u_legacy on shared stimulus.
module irq_dispatch_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  irq_line = '0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [4:0]  reg_wdata = '0;
    logic        ei = 1'b0, di = 1'b0, halt = 1'b0, bnd = 1'b0;
    logic [15:0] pc = '0, sp = '0;

    logic [4:0]  rdata, l_rdata;
    logic        ime, halted, busy, stk_we, pc_load, sp_load, evt_valid, evt_disp, refetch;
    logic [15:0] stk_addr, pc_val, sp_val;
    logic [7:0]  stk_data, evt_cyc;
    logic        l_ime, l_halted, l_busy, l_stk_we, l_pc_load, l_sp_load, l_evt_valid, l_evt_disp, l_refetch;
    logic [15:0] l_stk_addr, l_pc_val, l_sp_val;
    logic [7:0]  l_stk_data, l_evt_cyc;

    int total = 0;
    int failed = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dispatch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .irq_line_i(irq_line), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .ei_i(ei), .di_i(di), .halt_i(halt),
        .boundary_i(bnd), .pc_i(pc), .sp_i(sp), .ime_o(ime), .halted_o(halted), .busy_o(busy),
        .stk_we_o(stk_we), .stk_addr_o(stk_addr), .stk_data_o(stk_data), .pc_load_o(pc_load),
        .pc_val_o(pc_val), .sp_load_o(sp_load), .sp_val_o(sp_val), .evt_valid_o(evt_valid),
        .evt_disp_o(evt_disp), .evt_cyc_o(evt_cyc), .refetch_o(refetch)
    );

    irq_dispatch_unit #(.LEGACY_WAKE(1'b1)) u_legacy (
        .clk(clk), .rst_n(rst_n), .irq_line_i(irq_line), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(l_rdata), .ei_i(ei), .di_i(di), .halt_i(halt),
        .boundary_i(bnd), .pc_i(pc), .sp_i(sp), .ime_o(l_ime), .halted_o(l_halted), .busy_o(l_busy),
        .stk_we_o(l_stk_we), .stk_addr_o(l_stk_addr), .stk_data_o(l_stk_data), .pc_load_o(l_pc_load),
        .pc_val_o(l_pc_val), .sp_load_o(l_sp_load), .sp_val_o(l_sp_val), .evt_valid_o(l_evt_valid),
        .evt_disp_o(l_evt_disp), .evt_cyc_o(l_evt_cyc), .refetch_o(l_refetch)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [4:0] val);
        reg_sel = sel; reg_wdata = val; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [4:0] val);
        reg_sel = sel;
        #1;
        val = rdata;
    endtask

    task automatic pulse_ei();  ei = 1'b1;   tick(); ei = 1'b0;   endtask
    task automatic pulse_di();  di = 1'b1;   tick(); di = 1'b0;   endtask
    task automatic pulse_halt(); halt = 1'b1; tick(); halt = 1'b0; endtask
    task automatic boundary();  bnd = 1'b1;  tick(); bnd = 1'b0;  endtask

    initial begin
        logic [4:0] v;
        repeat (3) tick();
        // R13: reset state
        rd(1'b0, v); chk("R13 enable after reset", v, 0);
        rd(1'b1, v); chk("R13 request after reset", v, 0);
        chk("R13 ime after reset", ime, 0);
        chk("R13 halted after reset", halted, 0);
        chk("R13 no event/write/load", {evt_valid, stk_we, pc_load, sp_load}, 0);
        rst_n = 1'b1;
        tick();
        chk("R13 idle after release", {evt_valid, stk_we, pc_load, busy}, 0);

        // R12: line edges set and clear request bits
        irq_line = 5'b01000; tick();
        rd(1'b1, v); chk("R12 rise sets bit", v, 5'b01000);
        irq_line = 5'b00000; tick();
        rd(1'b1, v); chk("R12 fall clears bit", v, 0);

        // R7: first boundary after EI skipped
        wr(1'b0, 5'b00001); wr(1'b1, 5'b00001);
        pulse_ei();
        boundary();
        chk("R7 skipped boundary valid", evt_valid, 1);
        chk("R7 skipped boundary no dispatch", evt_disp, 0);
        chk("R7 skipped boundary cycles", evt_cyc, 0);
        chk("R7 ime still set", ime, 1);
        boundary();
        chk("R7 next boundary dispatches", evt_disp, 1);
        repeat (3) tick();

        // R1..R6: exhaustive sweep of enable x request
        for (int en = 0; en < 32; en++) begin
            for (int rq = 0; rq < 32; rq++) begin
                int pend;
                int win;
                pend = en & rq;
                win = -1;
                for (int b = 4; b >= 0; b--) if (pend[b]) win = b;
                wr(1'b0, 5'(en)); wr(1'b1, 5'(rq));
                pc = 16'h1234 + 16'(en * 37 + rq);
                sp = 16'hC000 + 16'(en * 4);
                pulse_ei();
                boundary();
                boundary();
                if (win < 0) begin
                    chk("R1 no pending no dispatch", {evt_valid, evt_disp, busy}, 3'b100);
                    chk("R1 no pending ime kept", ime, 1);
                end else begin
                    chk("R2 dispatch event", evt_disp, 1);
                    chk("R6 dispatch cycles", evt_cyc, 20);
                    chk("R4 ime cleared", ime, 0);
                    chk("R5 low byte write", {stk_we, stk_addr, stk_data}, {1'b1, sp - 16'd2, pc[7:0]});
                    tick();
                    chk("R5 high byte write", {stk_we, stk_addr, stk_data}, {1'b1, sp - 16'd1, pc[15:8]});
                    tick();
                    chk("R3 vector load", {pc_load, pc_val}, {1'b1, 16'h0040 + 16'(8 * win)});
                    chk("R5 sp load", {sp_load, sp_val, stk_we}, {1'b1, sp - 16'd2, 1'b0});
                    tick();
                    rd(1'b1, v); chk("R4 winning bit cleared", v, rq & ~(1 << win));
                    rd(1'b0, v); chk("R4 enable unchanged", v, en);
                end
            end
        end

        // R11/R8/R9/R10: halt with ime off, quiet boundary before wake
        pulse_di();
        wr(1'b0, 5'b00100); wr(1'b1, 5'b00000);
        pulse_halt();
        boundary();
        chk("R11 quiet halt cycles new", evt_cyc, 4);
        chk("R11 quiet halt cycles legacy", l_evt_cyc, 2);
        chk("R11 still halted", {halted, l_halted}, 2'b11);
        wr(1'b1, 5'b00100);
        boundary();
        chk("R8 wake clears halt", {halted, l_halted}, 2'b00);
        chk("R8 no dispatch with ime off", {evt_disp, l_evt_disp}, 2'b00);
        chk("R10 wake cycles new, after quiet", evt_cyc, 8);
        chk("R10 wake cycles legacy", l_evt_cyc, 0);
        chk("R9 refetch legacy", l_refetch, 1);
        chk("R9 no refetch new", refetch, 0);
        rd(1'b1, v); chk("R8 request unchanged", v, 5'b00100);

        // R10: wake at once after halt entry
        wr(1'b1, 5'b00000);
        pulse_halt();
        wr(1'b1, 5'b00100);
        boundary();
        chk("R10 wake cycles new, entering", evt_cyc, 4);
        chk("R9 refetch legacy again", l_refetch, 1);

        // R10: wake with dispatch
        wr(1'b1, 5'b00000);
        pulse_ei();
        boundary();
        pulse_halt();
        wr(1'b1, 5'b00100);
        boundary();
        chk("R10 wake+dispatch flags", {evt_disp, l_evt_disp, refetch, l_refetch}, 4'b1100);
        chk("R10 wake+dispatch cycles new", evt_cyc, 24);
        chk("R10 wake+dispatch cycles legacy", l_evt_cyc, 20);
        repeat (2) tick();
        chk("R3 halt dispatch vector", pc_val, 16'h0050);
        tick();
        chk("R8 not halted after dispatch", {halted, ime, busy}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule